// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block monitors a single watchdog input that the supervised logic is expected to toggle. Each level change on the input, rising or falling, restarts an internal cycle counter. If the input keeps the same level for a full timeout window, the active-low watchdog output drops. It stays low until activity resumes or the timer is cleared some other way.

The block also takes a supply-good flag and a system reset request. A low supply holds the output low and keeps the counter at zero. The output returns high in the same cycle the supply flag rises again. A system reset request only clears the counter. The watchdog input is asynchronous and passes through a two-flop synchroniser before edge detection.

Top module: `wdt_activity`

## Requirements
- R1: While `rst_ni` is low and `supply_ok_i` is high, `wd_n_o` is high.
- R2: A rising edge on `wdi_i` clears the counter. Counting from the input change, the clear lands on the third rising clock edge.
- R3: A falling edge on `wdi_i` clears the counter with the same three-clock latency as R2.
- R4: With no clear, `wd_n_o` goes low exactly TIMEOUT clock edges after the edge that cleared the counter. It is still high one edge earlier.
- R5: Once low from a timeout, `wd_n_o` stays low for as long as no clear occurs. The counter saturates at TIMEOUT and does not wrap.
- R6: An input edge after a timeout returns `wd_n_o` high on the third clock edge after the input change. The output is still low after the second.
- R7: While `sys_rst_i` is high, the counter is held at zero on every clock edge and `wd_n_o` stays high. After release, the timeout window starts again from zero.
- R8: When `supply_ok_i` is low, `wd_n_o` is low in the same cycle and the counter is held at zero.
- R9: When `supply_ok_i` rises again, `wd_n_o` is high in that same cycle with no hold delay. This holds even if a timeout had occurred before the supply dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wdi_i | input | 1 | Asynchronous watchdog activity input |
| supply_ok_i | input | 1 | Supply above threshold when high |
| sys_rst_i | input | 1 | System reset request, clears the timer when high |
| wd_n_o | output | 1 | Watchdog output, low on timeout or low supply |

## Verification
The assertions take `supply_ok_i` and `sys_rst_i` to be synchronous to `clk_i`. They also take any change on `wdi_i` to be held for at least two clocks, so the synchroniser sees every level. The stimulus changes all inputs just after a falling clock edge. It holds each `wdi_i` level for at least three clocks, so every toggle yields exactly one detected edge. The supply flag is treated as combinational toward the output. Its same-cycle effect is checked immediately after the change rather than at a clock edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DEF_TIMEOUT = 16;
  localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned STAGES = wdt_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/wdt_edge.sv
module wdt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  // either direction counts as activity
  assign edge_o = lvl_i ^ prev_q;

  // R2
  edge_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (prev_q == $past(lvl_i)));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned TIMEOUT = wdt_pkg::DEF_TIMEOUT,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;

  assign expired_o = (cnt_q == LIMIT);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);

  // R2
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  // R4
  expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LIMIT - 1'b1 && !clr_i) |=> expired_o);
endmodule

// File: rtl/wdt_activity.sv
module wdt_activity #(
  parameter int unsigned TIMEOUT     = wdt_pkg::DEF_TIMEOUT,
  parameter int unsigned SYNC_STAGES = wdt_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_i,
  input  logic supply_ok_i,
  input  logic sys_rst_i,
  output logic wd_n_o
);
  logic wdi_s, act_edge, clr, expired;

  wdt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wdi_i), .q_o(wdi_s)
  );

  wdt_edge i_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(wdi_s), .edge_o(act_edge)
  );

  // low supply and system reset both restart the window
  assign clr = act_edge | sys_rst_i | ~supply_ok_i;

  wdt_counter #(.TIMEOUT(TIMEOUT)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .expired_o(expired)
  );

  assign wd_n_o = supply_ok_i & ~expired;

  // R9
  supply_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(supply_ok_i) |-> wd_n_o);

  // R5
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wd_n_o && !clr) |=> !wd_n_o);

  // R7
  sys_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && supply_ok_i) |=> (wd_n_o || !supply_ok_i));
endmodule

// File: tb/test_wdt_activity.sv
module test_wdt_activity;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 16;

  logic clk = 1'b0, rst_ni = 1'b0, wdi = 1'b0, supply_ok = 1'b1, sys_rst = 1'b0;
  logic wd_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_activity #(.TIMEOUT(TO)) i_wdt_activity (
    .clk_i(clk), .rst_ni(rst_ni), .wdi_i(wdi), .supply_ok_i(supply_ok),
    .sys_rst_i(sys_rst), .wd_n_o(wd_n)
  );

  task automatic chk(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wd_n_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk)
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(wd_n, it.exp, it.tag);
    end

  // driver: advance n clock edges, then queue expected output
  task automatic step(int n, logic exp, string tag);
    item_t it;
    repeat (n) @(posedge clk);
    #1;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  initial begin
    @(negedge clk); #1;
    step(3, 1'b1, "R1");
    rst_ni = 1'b1;

    wdi = 1'b1;                       // R2 rising edge
    step(TO + 2, 1'b1, "R2");
    step(1, 1'b0, "R4");
    step(40, 1'b0, "R5");

    wdi = 1'b0;                       // R6, R3 falling edge after timeout
    step(2, 1'b0, "R6");
    step(1, 1'b1, "R6");
    step(TO - 1, 1'b1, "R3");
    step(1, 1'b0, "R3");

    wdi = 1'b1;
    step(8, 1'b1, "R2");
    sys_rst = 1'b1;                   // R7
    step(1, 1'b1, "R7");
    step(30, 1'b1, "R7");
    sys_rst = 1'b0;
    step(TO - 1, 1'b1, "R7");
    step(1, 1'b0, "R7");

    wdi = 1'b0;
    step(3, 1'b1, "R6");
    supply_ok = 1'b0;                 // R8
    #1 chk(wd_n, 1'b0, "R8");
    step(30, 1'b0, "R8");
    supply_ok = 1'b1;                 // R9
    #1 chk(wd_n, 1'b1, "R9");
    step(TO - 1, 1'b1, "R8");
    step(1, 1'b0, "R8");

    supply_ok = 1'b0;                 // R9 after a timeout
    step(1, 1'b0, "R8");
    supply_ok = 1'b1;
    #1 chk(wd_n, 1'b1, "R9");
    step(2, 1'b1, "R9");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule